// File: doc/BRIEF.md
# Variable-pulse-width serial frame transmitter

This block sends one frame at a time onto a single-wire multiplex bus that uses variable-pulse-width bit coding at 10.4 kbps. Software first writes the header bytes and the data bytes into a small transmit buffer. It then pulses `start` and gives the header length (one or three bytes) and the data byte count. The block appends a CRC-8 byte that it computes itself. It waits until the bus has been quiet for an end-of-frame interval. It then drives a start delimiter, every payload bit and CRC bit most significant bit first, and an end delimiter, and finally returns the bus to its passive level.

Every bit is a single bus symbol, and consecutive symbols alternate in level. The width of a symbol depends on the bit value and on the level of that symbol. Any number of nodes may begin a frame at the same moment. The block compares the level it drives with the level it senses. If it is driving passive while the bus reads active, it has lost arbitration: it releases the bus at once, raises a one-cycle flag and waits for the bus to go idle again. It then sends the whole frame again from the start delimiter, with no help from software.

All symbol lengths are counts of a microsecond tick, and that tick is a fixed number of clock cycles (`TICK_DIV`). A symbol that lasts N ticks therefore lasts N × `TICK_DIV` clock cycles.

Top module: `vpw_tx`

## Requirements
- R1: A frame is sent as follows: an active start delimiter of `DELIM_TICKS` ticks, then the payload bytes in buffer order starting at address 0, each most significant bit first, then the CRC byte, then a passive end delimiter of `DELIM_TICKS` ticks. After that the bus stays passive. `bus_drive` = 1 means the active level.
- R2: The first bit symbol after the start delimiter is passive, and the levels alternate from then on. A bit of 1 is a passive short symbol or an active long symbol. A bit of 0 is a passive long symbol or an active short symbol.
- R3: The payload is the header followed by the data. The header is 3 bytes when `hdr_long` = 1 and 1 byte when `hdr_long` = 0. The data is `data_cnt` bytes, with `data_cnt` from 0 to 8. A frame of 12 bytes (3 + 8 + CRC) is sent normally.
- R4: A start with `data_cnt` > 8, or with a frame (header + data + CRC) longer than 12 bytes, sends nothing. It raises `len_err` for exactly one cycle in the cycle after the start, and `busy` stays low.
- R5: The CRC byte is CRC-8 over all the payload bits in the order they are sent. The polynomial is 0x1D (x^8+x^4+x^3+x^2+1), the register starts at 0xFF, and the result is inverted before it is sent.
- R6: The start delimiter begins only after the bus has been sensed passive for `IDLE_TICKS` ticks. It begins exactly `IDLE_TICKS`×`TICK_DIV`+2 cycles after the first passive cycle on the bus. If the bus has already been quiet for that long, it begins 2 cycles after the cycle in which `start` is sampled.
- R7: A sensed active level during one of the block's own passive bit symbols is a lost arbitration. The first `TICK_DIV` cycles of each symbol are excluded from this test. On a loss the block keeps `bus_drive` low and pulses `arb_lost` for one cycle. The pulse comes one cycle after the first cycle in which the sampled bus reads active outside the excluded window.
- R8: After a loss, the block waits for the idle interval of R6 and then sends the same frame again, complete from the start delimiter.
- R9: `busy` is high from the cycle after an accepted start until `done` rises. `done` is a one-cycle pulse in the cycle after the end delimiter's last cycle, and `busy` is low in that cycle.
- R10: A short symbol lasts `SHORT_TICKS`, a long symbol `LONG_TICKS`, each delimiter `DELIM_TICKS`, and the idle interval `IDLE_TICKS`. Each tick is `TICK_DIV` clock cycles.
- R11: After reset, `bus_drive`, `busy`, `done`, `arb_lost` and `len_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Write strobe for the transmit buffer, ignored while busy |
| ld_addr | input | 4 | Buffer byte address (payload position) |
| ld_data | input | 8 | Buffer write data |
| hdr_long | input | 1 | 1 = three-byte header, 0 = one-byte header |
| data_cnt | input | 4 | Number of data bytes after the header |
| start | input | 1 | Start strobe, accepted when idle |
| bus_sense | input | 1 | Sensed bus level, 1 = active |
| bus_drive | output | 1 | Driven bus level, 1 = active |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at end of frame |
| arb_lost | output | 1 | One-cycle pulse on lost arbitration |
| len_err | output | 1 | One-cycle pulse on a rejected length |

## Verification
The bench builds the block with `TICK_DIV` = 2 and with 3, 6, 10 and 14 ticks for short, long, delimiter and idle. Every symbol is then only a few cycles long, so frames of the full 12-byte length, a held-active bus before the start, and a second node that wins on a passive symbol or on an active symbol all fit easily into the run. A tick of two cycles also makes the guard window wider than one cycle. This checks that the arbitration test waits for the whole first tick of a symbol, and not only for its first clock.

// File: rtl/vpw_pkg.sv
package vpw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SOF,
    ST_BITS,
    ST_EOD
  } vpw_state_t;

  localparam logic [7:0] CRC_POLY = 8'h1D;
  localparam logic [7:0] CRC_SEED = 8'hFF;

  // one bit of the CRC-8 shift register, message bit enters at the top
  function automatic logic [7:0] crc_bit(input logic [7:0] c, input logic b);
    logic fb;
    fb = c[7] ^ b;
    return {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
  endfunction

endpackage

// File: rtl/vpw_txbuf.sv
module vpw_txbuf #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port so the array maps onto block RAM
  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/vpw_crc8.sv
module vpw_crc8
  import vpw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       seed,
  input  logic       step,
  input  logic       bit_in,
  output logic [7:0] crc
);
  always_ff @(posedge clk) begin
    if (rst || seed) crc <= CRC_SEED;
    else if (step)   crc <= crc_bit(crc, bit_in);
  end
endmodule

// File: rtl/vpw_carrier.sv
module vpw_carrier #(
  parameter int IDLE_C = 28000
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_sense,
  output logic sense_q,
  output logic bus_free
);
  localparam int IW = $clog2(IDLE_C + 1);
  localparam logic [IW-1:0] IDLE_L = IW'(IDLE_C);

  logic [IW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q  <= 1'b1;
      idle_cnt <= '0;
    end else begin
      sense_q <= bus_sense;
      if (sense_q)               idle_cnt <= '0;
      else if (idle_cnt != IDLE_L) idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assign bus_free = (idle_cnt == IDLE_L) && !sense_q;

  // R6: the quiet counter never runs past its limit
  p_idle_sat_r6: assert property (@(posedge clk) disable iff (rst)
    idle_cnt <= IDLE_L);
endmodule

// File: rtl/vpw_tx.sv
module vpw_tx
  import vpw_pkg::*;
#(
  parameter int TICK_DIV    = 100,
  parameter int SHORT_TICKS = 64,
  parameter int LONG_TICKS  = 128,
  parameter int DELIM_TICKS = 200,
  parameter int IDLE_TICKS  = 280,
  parameter int MAX_DATA    = 8,
  parameter int MAX_FRAME   = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ld_we,
  input  logic [3:0] ld_addr,
  input  logic [7:0] ld_data,
  input  logic       hdr_long,
  input  logic [3:0] data_cnt,
  input  logic       start,
  input  logic       bus_sense,
  output logic       bus_drive,
  output logic       busy,
  output logic       done,
  output logic       arb_lost,
  output logic       len_err
);
  localparam int AW      = 4;
  localparam int SHORT_C = SHORT_TICKS * TICK_DIV;
  localparam int LONG_C  = LONG_TICKS * TICK_DIV;
  localparam int DELIM_C = DELIM_TICKS * TICK_DIV;
  localparam int IDLE_C  = IDLE_TICKS * TICK_DIV;
  localparam int GUARD_C = TICK_DIV;
  localparam int SYM_MAX = (LONG_C > DELIM_C) ? LONG_C : DELIM_C;
  localparam int CW      = $clog2(SYM_MAX + 1);
  localparam logic [CW-1:0] SHORT_L = CW'(SHORT_C - 1);
  localparam logic [CW-1:0] LONG_L  = CW'(LONG_C - 1);
  localparam logic [CW-1:0] DELIM_L = CW'(DELIM_C - 1);
  localparam logic [CW-1:0] GUARD_L = CW'(GUARD_C);

  vpw_state_t    state;
  logic [CW-1:0] sym_cnt;
  logic [AW-1:0] byte_idx;
  logic [2:0]    bit_idx;
  logic [AW-1:0] n_pay;
  logic [7:0]    rdata;
  logic [7:0]    crc;
  logic          sense_q;
  logic          bus_free;

  // length decode
  logic [5:0] tot_len;
  logic       len_bad;
  assign tot_len = 6'(data_cnt) + (hdr_long ? 6'd3 : 6'd1) + 6'd1;
  assign len_bad = (int'(data_cnt) > MAX_DATA) || (int'(tot_len) > MAX_FRAME);

  // current bit and its symbol width
  logic          in_crc;
  logic          cur_bit;
  logic [CW-1:0] sym_last;
  logic          sym_end;
  logic          arb_hit;

  assign in_crc   = (byte_idx == n_pay);
  assign cur_bit  = in_crc ? ~crc[~bit_idx] : rdata[~bit_idx];
  assign sym_last = (cur_bit ^ bus_drive) ? SHORT_L : LONG_L;
  assign sym_end  = (sym_cnt == sym_last);
  assign arb_hit  = (state == ST_BITS) && !bus_drive && (sym_cnt >= GUARD_L) && sense_q;

  vpw_txbuf #(.AW(AW)) u_buf (
    .clk   (clk),
    .we    (ld_we && !busy),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (byte_idx),
    .rdata (rdata)
  );

  vpw_crc8 u_crc (
    .clk    (clk),
    .rst    (rst),
    .seed   (state == ST_WAIT),
    .step   ((state == ST_BITS) && sym_end && !in_crc && !arb_hit),
    .bit_in (cur_bit),
    .crc    (crc)
  );

  vpw_carrier #(.IDLE_C(IDLE_C)) u_cs (
    .clk       (clk),
    .rst       (rst),
    .bus_sense (bus_sense),
    .sense_q   (sense_q),
    .bus_free  (bus_free)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sym_cnt   <= '0;
      byte_idx  <= '0;
      bit_idx   <= '0;
      n_pay     <= '0;
      bus_drive <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      arb_lost  <= 1'b0;
      len_err   <= 1'b0;
    end else begin
      done     <= 1'b0;
      arb_lost <= 1'b0;
      len_err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (len_bad) begin
              len_err <= 1'b1;
            end else begin
              n_pay <= AW'(tot_len - 6'd1);
              busy  <= 1'b1;
              state <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (bus_free) begin
            state     <= ST_SOF;
            bus_drive <= 1'b1;
            sym_cnt   <= '0;
            byte_idx  <= '0;
            bit_idx   <= '0;
          end
        end
        ST_SOF: begin
          if (sym_cnt == DELIM_L) begin
            state     <= ST_BITS;
            bus_drive <= 1'b0;
            sym_cnt   <= '0;
          end else begin
            sym_cnt <= sym_cnt + 1'b1;
          end
        end
        ST_BITS: begin
          if (arb_hit) begin
            state    <= ST_WAIT;
            arb_lost <= 1'b1;
          end else if (sym_end) begin
            sym_cnt   <= '0;
            bit_idx   <= bit_idx + 1'b1;
            bus_drive <= ~bus_drive;
            if (bit_idx == 3'd7) begin
              if (in_crc) state <= ST_EOD;
              else        byte_idx <= byte_idx + 1'b1;
            end
          end else begin
            sym_cnt <= sym_cnt + 1'b1;
          end
        end
        ST_EOD: begin
          if (sym_cnt == DELIM_L) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end else begin
            sym_cnt <= sym_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: no drive while the bus has not been quiet long enough
  p_wait_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !bus_free) |=> !bus_drive);

  // R1: start delimiter is driven active throughout
  p_sof_active_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SOF) |-> bus_drive);

  // R7: a loss leaves the bus released and the frame still pending
  p_lost_release_r7: assert property (@(posedge clk) disable iff (rst)
    arb_lost |-> (!bus_drive && busy));

  // R9: done ends busy and leaves the bus passive
  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !bus_drive));

  // R4: a rejected length never starts a frame
  p_err_idle_r4: assert property (@(posedge clk) disable iff (rst)
    len_err |-> (!busy && !bus_drive));

  // R9: the status pulses never coincide
  p_flags_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, arb_lost, len_err}));

  // R10: a bit symbol never outlasts a long pulse
  p_sym_bound_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BITS) |-> (sym_cnt <= LONG_L));
endmodule

// File: tb/vpw_tx_tb.sv
module vpw_tx_tb;
  localparam int TD  = 2;
  localparam int SC  = 3 * TD;
  localparam int LC  = 6 * TD;
  localparam int DC  = 10 * TD;
  localparam int IC  = 14 * TD;
  localparam int GRD = TD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_we = 1'b0;
  logic [3:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic hdr_long = 1'b0;
  logic [3:0] data_cnt = '0;
  logic start = 1'b0;
  logic other = 1'b0;
  logic bus_sense;
  logic bus_drive, busy, done, arb_lost, len_err;

  always #5 clk = ~clk;
  assign bus_sense = bus_drive | other;

  vpw_tx #(
    .TICK_DIV(TD), .SHORT_TICKS(3), .LONG_TICKS(6),
    .DELIM_TICKS(10), .IDLE_TICKS(14)
  ) u_dut (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .hdr_long(hdr_long), .data_cnt(data_cnt), .start(start),
    .bus_sense(bus_sense), .bus_drive(bus_drive), .busy(busy), .done(done),
    .arb_lost(arb_lost), .len_err(len_err)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  int cyc = 0;

  logic [7:0] fa [11];
  logic [7:0] fb [11];
  int wa[$];
  int wb[$];
  int ed[$];

  // run settings
  int k_hold;
  bit use_arb;
  int r0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 190000 && !finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // expected bus waveform for a frame, one entry per clock cycle
  task automatic build(input logic [7:0] fr [11], input int n, ref int q[$]);
    logic [7:0] c;
    logic [7:0] bytes [12];
    int lvl;
    q.delete();
    c = 8'hFF;
    for (int i = 0; i < n; i++) begin
      bytes[i] = fr[i];
      for (int b = 7; b >= 0; b--) begin
        logic f;
        f = c[7] ^ fr[i][b];
        c = {c[6:0], 1'b0} ^ (f ? 8'h1D : 8'h00);
      end
    end
    bytes[n] = ~c;
    repeat (DC) q.push_back(1);
    lvl = 0;
    for (int i = 0; i <= n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        int d;
        d = ((int'(bytes[i][b]) ^ lvl) != 0) ? SC : LC;
        repeat (d) q.push_back(lvl);
        lvl ^= 1;
      end
    end
    repeat (DC) q.push_back(0);
  endtask

  function automatic int oth(input int t);
    if (k_hold > 0 && t < k_hold) return 1;
    if (use_arb && t >= r0 && (t - r0) < wb.size()) return wb[t - r0];
    return 0;
  endfunction

  task automatic load(input logic [7:0] fr [11], input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = 4'(i); ld_data = fr[i];
    end
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic run(input bit h3, input int dn, input int kh, input bit arb, input string tag);
    int n, done_t, lost_t, end_t;
    int bd, bdn, bb, bl, xd, xdn, xb, xl, ad, adn, ab, al;
    n = (h3 ? 3 : 1) + dn;
    k_hold = kh;
    use_arb = arb;
    load(fa, n);
    build(fa, n, wa);
    if (arb) build(fb, n, wb);
    r0 = (kh > 0) ? kh + IC + 2 : 0;
    ed.delete();
    lost_t = -100;
    repeat (r0) ed.push_back(0);
    if (!arb) begin
      foreach (wa[i]) ed.push_back(wa[i]);
      done_t = r0 + wa.size();
    end else begin
      int j, ss, lb, r1;
      j = -1; ss = 0;
      for (int i = 0; i < wa.size(); i++) begin
        if (i == 0 || wa[i] != wa[i-1]) ss = i;
        if (wa[i] == 0 && wb[i] == 1) begin j = r0 + i; break; end
      end
      lost_t = ((j + 1) > (r0 + ss + GRD) ? (j + 1) : (r0 + ss + GRD)) + 1;
      lb = 0;
      foreach (wb[i]) if (wb[i] == 1) lb = r0 + i;
      r1 = lb + 1 + IC + 2;
      for (int i = 0; i < j - r0; i++) ed.push_back(wa[i]);
      while (ed.size() < r1) ed.push_back(0);
      foreach (wa[i]) ed.push_back(wa[i]);
      done_t = r1 + wa.size();
    end
    end_t = done_t + 3;
    while (ed.size() <= end_t) ed.push_back(0);
    // pre-start bus conditions
    if (kh > 0) begin
      @(negedge clk); other = 1'b1;
      repeat (6) @(negedge clk);
    end else begin
      repeat (IC + 6) @(negedge clk);
    end
    @(negedge clk);
    start = 1'b1; hdr_long = h3; data_cnt = 4'(dn);
    other = 1'(oth(-2));
    bd = -1; bdn = -1; bb = -1; bl = -1;
    xd = 0; xdn = 0; xb = 0; xl = 0; ad = 0; adn = 0; ab = 0; al = 0;
    for (int t = -1; t <= end_t; t++) begin
      int e, edn, eb, el;
      @(negedge clk);
      start = 1'b0;
      e   = (t < 0) ? 0 : ed[t];
      edn = (t == done_t) ? 1 : 0;
      eb  = (t < done_t) ? 1 : 0;
      el  = (t == lost_t) ? 1 : 0;
      if (bd < 0 && int'(bus_drive) != e)  begin bd = t;  xd = e;  ad = int'(bus_drive); end
      if (bdn < 0 && int'(done) != edn)    begin bdn = t; xdn = edn; adn = int'(done); end
      if (bb < 0 && int'(busy) != eb)      begin bb = t;  xb = eb;  ab = int'(busy); end
      if (bl < 0 && int'(arb_lost) != el)  begin bl = t;  xl = el;  al = int'(arb_lost); end
      other = 1'(oth(t));
    end
    other = 1'b0;
    chk(bd < 0,  $sformatf("%s bus waveform at cycle %0d", tag, bd), ad, xd);
    chk(bdn < 0, $sformatf("R9 done pulse at cycle %0d", bdn), adn, xdn);
    chk(bb < 0,  $sformatf("R9 busy window at cycle %0d", bb), ab, xb);
    chk(bl < 0,  $sformatf("R7 arb_lost at cycle %0d", bl), al, xl);
  endtask

  task automatic run_err(input bit h3, input int dn);
    int bad;
    bad = 0;
    repeat (4) @(negedge clk);
    start = 1'b1; hdr_long = h3; data_cnt = 4'(dn);
    @(negedge clk);
    start = 1'b0;
    chk(len_err == 1'b1, "R4 len_err after bad start", int'(len_err), 1);
    chk(busy == 1'b0, "R4 busy stays low", int'(busy), 0);
    @(negedge clk);
    chk(len_err == 1'b0, "R4 len_err is one cycle", int'(len_err), 0);
    repeat (IC) begin
      @(negedge clk);
      if (bus_drive || busy) bad = 1;
    end
    chk(bad == 0, "R4 no frame after bad start", bad, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk({bus_drive, busy, done, arb_lost, len_err} == 5'b0, "R11 outputs after reset",
        int'({bus_drive, busy, done, arb_lost, len_err}), 0);

    // R1 R2 R5 R6: single header byte, no data
    fa[0] = 8'h5A;
    run(1'b0, 0, 0, 1'b0, "R1 R2 R5 R6 one-byte frame");

    // R3: one header byte and eight data bytes
    for (int i = 0; i < 9; i++) fa[i] = 8'(8'h13 * i + 8'h07);
    run(1'b0, 8, 0, 1'b0, "R3 R5 header1 data8");

    // R3 R10: 12-byte frame, the longest allowed
    for (int i = 0; i < 11; i++) fa[i] = 8'(8'hF0 ^ (i * 8'h25));
    run(1'b1, 8, 0, 1'b0, "R3 R10 header3 data8");

    // R6: bus held active before the start
    fa[0] = 8'hC3; fa[1] = 8'h00; fa[2] = 8'hFF; fa[3] = 8'h81; fa[4] = 8'h3C;
    run(1'b1, 2, 40, 1'b0, "R6 carrier wait");

    // R7 R8: loss on a passive symbol (first bit)
    fa[0] = 8'h00; fa[1] = 8'h11;
    fb[0] = 8'h80; fb[1] = 8'h11;
    run(1'b0, 1, 0, 1'b1, "R7 R8 passive-symbol loss and retry");

    // R7 R8: loss on an active symbol (second bit)
    fa[0] = 8'h80; fa[1] = 8'h22;
    fb[0] = 8'hC0; fb[1] = 8'h22;
    run(1'b0, 1, 0, 1'b1, "R7 R8 active-symbol loss and retry");

    // R4: too many data bytes, with both header lengths
    run_err(1'b0, 9);
    run_err(1'b1, 9);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule